// File: doc/BRIEF.md
# Interrupt-to-DMA Request Router

This block sits between peripheral interrupt causes and the CPU interrupt line. Each of its sources has two software-visible bits: a DMA-request bit and a DMA-enable bit. When a source raises a cause event while both bits are 1, the event is held as a pending DMA job and is not routed to the CPU. The block then asks the DMA engine to start the channel that a fixed parameter table assigns to that source. Any other event from the source sets its CPU interrupt flag directly.

Each of the two registers has its own write mode. In the set-only mode, which is the reset default, a written 1 sets a bit and a written 0 changes nothing. In the read/write mode, a write loads the whole register. Starting a DMA job ignores all interrupt masking and priority. When a non-linked transfer finishes, the CPU interrupt flag of that source is raised, and that flag then passes through the normal mask, global enable and level gate. When a linked chain finishes, no CPU interrupt is raised.

Only one start is outstanding at a time. When several jobs are pending, the lowest-numbered source wins. When the engine accepts a start, the request bit of that source is cleared by hardware.

Top module: `irq_dma_router`

## Requirements
- R1: After reset the request register (address 0) and the enable register (address 1) read 0. The mode register (address 2) reads 3. No DMA start and no CPU interrupt is asserted.
- R2: In set-only mode, a write ORs the written data into the register, so a bit written as 0 keeps its value.
- R3: In read/write mode, a write replaces the register contents, so a bit written as 0 is cleared.
- R4: Mode register bit 0 selects set-only mode (1) for the request register. Bit 1 does the same for the enable register. Both bits are readable and writable, and each affects only its own register.
- R5: A source event with request=1 and enable=1 produces a DMA start and no CPU flag. An event with either bit 0 sets that source's CPU interrupt flag.
- R6: A DMA start is issued regardless of the interrupt mask, the global enable, the source level and the CPU level.
- R7: The channel number for source i is nibble i of CHAN_MAP. By default source i maps to channel 15-2i.
- R8: When dma_ack is high during a start, the request bit of the chosen source clears. This hardware clear wins over a software write to the request register in the same cycle.
- R9: Only one start is outstanding at a time. The lowest-numbered pending source goes first. No new start is issued until dma_done.
- R10: dma_done with dma_linked=0 sets the CPU interrupt flag of the source that was served.
- R11: dma_done with dma_linked=1 sets no CPU interrupt flag.
- R12: irq_src[i] is high when flag i is set, irq_mask[i]=1, cpu_gie=1 and the 3-bit level of source i is strictly greater than cpu_lvl. cpu_ack[i] clears flag i. cpu_irq is the OR of irq_src.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 request, 1 enable, 2 mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| src_evt | input | 8 | One-cycle cause event per source |
| src_lvl | input | 24 | 3-bit priority level per source, source i at [3i+2:3i] |
| irq_mask | input | 8 | Per-source CPU interrupt enable |
| cpu_gie | input | 1 | CPU global interrupt enable |
| cpu_lvl | input | 3 | Current CPU interrupt level |
| cpu_ack | input | 8 | Clears the CPU interrupt flag per source |
| dma_start | output | 1 | DMA start request |
| dma_chan | output | 4 | Channel to start |
| dma_ack | input | 1 | Engine accepts the start |
| dma_done | input | 1 | Transfer complete |
| dma_linked | input | 1 | The completed transfer was a linked chain |
| irq_src | output | 8 | Gated per-source CPU interrupt requests |
| cpu_irq | output | 1 | CPU interrupt request |

## Verification
The in-line assertions check the following on every cycle:
- In set-only mode a write never drops a bit.
- A hardware clear always leaves its bit at 0.
- An accepted start is followed by a quiet start line, and the served source index stays fixed while a transfer is in flight.
- A linked completion adds no CPU flag beyond those that new events cause.

Some behaviours can only be shown by the bench scenarios. These are the lowest-first order between sources that fire together, the channel number that the map assigns, the bypass of masking and levels when a job is started, and the mask, enable and level gating of the flag raised after a plain transfer.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [1:0] {
    ADDR_REQ  = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_MODE = 2'd2,
    ADDR_NONE = 2'd3
  } irqd_addr_e;

  // next register contents on a software write
  function automatic logic [63:0] sw_merge(input logic [63:0] cur,
                                           input logic [63:0] wdat,
                                           input logic set_only);
    return set_only ? (cur | wdat) : wdat;
  endfunction
endpackage

// File: rtl/irqd_flag_reg.sv
module irqd_flag_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         set_only,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  import irqd_pkg::*;

  logic [W-1:0] sw_next;
  logic [63:0]  merged;

  always_comb begin
    merged  = sw_merge(64'(q), 64'(wdata), set_only);
    sw_next = wr ? merged[W-1:0] : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= sw_next & ~hw_clr;
  end

  AST_SETONLY_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && set_only && hw_clr == '0) |=> ((q & $past(q)) == $past(q))); // R2
  AST_HWCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr != '0) |=> ((q & $past(hw_clr)) == '0)); // R8
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
  parameter int               NSRC     = 8,
  parameter int               CHW      = 4,
  parameter logic [NSRC*CHW-1:0] CHAN_MAP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend,
  input  logic             dma_ack,
  input  logic             dma_done,
  input  logic             dma_linked,
  output logic             dma_start,
  output logic [CHW-1:0]   dma_chan,
  output logic [NSRC-1:0]  take,
  output logic [NSRC-1:0]  done_plain,
  output logic             busy,
  output logic             linked_fin
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  function automatic logic [IW-1:0] lowest_idx(input logic [NSRC-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = IW'(i);
    return r;
  endfunction

  logic [IW-1:0] sel_idx, cur;
  logic          accept, finish;

  always_comb begin
    sel_idx    = lowest_idx(pend);
    dma_start  = !busy && (pend != '0);
    dma_chan   = CHAN_MAP[sel_idx*CHW +: CHW];
    accept     = dma_start && dma_ack;
    finish     = busy && dma_done;
    take       = accept ? (NSRC'(1) << sel_idx) : '0;
    done_plain = (finish && !dma_linked) ? (NSRC'(1) << cur) : '0;
    linked_fin = finish && dma_linked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cur  <= sel_idx;
    end else if (finish) begin
      busy <= 1'b0;
    end
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !dma_start); // R9
  AST_SERVED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dma_done) |=> $stable(cur)); // R9
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router #(
  parameter int                  NSRC     = 8,
  parameter int                  CHW      = 4,
  parameter int                  LW       = 3,
  parameter logic [NSRC*CHW-1:0] CHAN_MAP = 32'h1357_9BDF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [NSRC-1:0]    bus_wdata,
  output logic [NSRC-1:0]    bus_rdata,
  input  logic [NSRC-1:0]    src_evt,
  input  logic [NSRC*LW-1:0] src_lvl,
  input  logic [NSRC-1:0]    irq_mask,
  input  logic               cpu_gie,
  input  logic [LW-1:0]      cpu_lvl,
  input  logic [NSRC-1:0]    cpu_ack,
  output logic               dma_start,
  output logic [CHW-1:0]     dma_chan,
  input  logic               dma_ack,
  input  logic               dma_done,
  input  logic               dma_linked,
  output logic [NSRC-1:0]    irq_src,
  output logic               cpu_irq
);
  import irqd_pkg::*;

  function automatic logic [NSRC-1:0] level_above(input logic [NSRC*LW-1:0] lv,
                                                  input logic [LW-1:0] floor_lvl);
    logic [NSRC-1:0] r;
    for (int i = 0; i < NSRC; i++) r[i] = lv[i*LW +: LW] > floor_lvl;
    return r;
  endfunction

  logic [1:0]      mode_q;          // [0] request set-only, [1] enable set-only
  logic [NSRC-1:0] req_q, en_q, dma_pend, irq_flag;
  logic [NSRC-1:0] take, done_plain, to_dma, to_cpu, no_clr;
  logic            wr_req, wr_en, arb_busy, linked_fin;

  assign wr_req = bus_wr && (bus_addr == ADDR_REQ);
  assign wr_en  = bus_wr && (bus_addr == ADDR_EN);
  assign no_clr = '0;

  irqd_flag_reg #(.W(NSRC)) u_req (
    .clk(clk), .rst_n(rst_n), .wr(wr_req), .wdata(bus_wdata),
    .set_only(mode_q[0]), .hw_clr(take), .q(req_q));

  irqd_flag_reg #(.W(NSRC)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(wr_en), .wdata(bus_wdata),
    .set_only(mode_q[1]), .hw_clr(no_clr), .q(en_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 2'b11;
    else if (bus_wr && bus_addr == ADDR_MODE) mode_q <= bus_wdata[1:0];
  end

  always_comb begin
    unique case (irqd_addr_e'(bus_addr))
      ADDR_REQ:  bus_rdata = req_q;
      ADDR_EN:   bus_rdata = en_q;
      ADDR_MODE: bus_rdata = NSRC'(mode_q);
      default:   bus_rdata = '0;
    endcase
  end

  // event routing: both bits set -> DMA job, otherwise CPU flag
  assign to_dma = src_evt & req_q & en_q;
  assign to_cpu = src_evt & ~(req_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_pend <= '0;
      irq_flag <= '0;
    end else begin
      dma_pend <= (dma_pend | to_dma) & ~take;
      irq_flag <= (irq_flag | to_cpu | done_plain) & ~cpu_ack;
    end
  end

  irqd_arbiter #(.NSRC(NSRC), .CHW(CHW), .CHAN_MAP(CHAN_MAP)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(dma_pend),
    .dma_ack(dma_ack), .dma_done(dma_done), .dma_linked(dma_linked),
    .dma_start(dma_start), .dma_chan(dma_chan), .take(take),
    .done_plain(done_plain), .busy(arb_busy), .linked_fin(linked_fin));

  assign irq_src = irq_flag & irq_mask & {NSRC{cpu_gie}} & level_above(src_lvl, cpu_lvl);
  assign cpu_irq = |irq_src;

  AST_LINKED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    linked_fin |=> ((irq_flag & ~$past(irq_flag) & ~$past(src_evt)) == '0)); // R11
  AST_TAKE_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (take != '0) |-> ((take & dma_pend) == take && $onehot0(take))); // R9
endmodule

// File: tb/irq_dma_router_test.sv
module irq_dma_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 0, rst_n = 0;
  logic         bus_wr = 0;
  logic [1:0]   bus_addr = 0;
  logic [7:0]   bus_wdata = 0, bus_rdata;
  logic [7:0]   src_evt = 0, irq_mask = 8'hFF, cpu_ack = 0, irq_src;
  logic [23:0]  src_lvl = {8{3'd5}};
  logic         cpu_gie = 1;
  logic [2:0]   cpu_lvl = 0;
  logic         dma_start, dma_ack = 0, dma_done = 0, dma_linked = 0, cpu_irq;
  logic [3:0]   dma_chan;
  int           n_chk = 0, n_bad = 0;
  bit           finished = 0;

  irq_dma_router uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] exp_chan(input int src);
    return 4'(15 - 2*src);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick; bus_wr = 0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    bus_addr = a; #1; check(req, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    src_evt = e; tick; src_evt = 0;
  endtask

  task automatic t_reset;
    rd_chk("R1 req", 0, 8'h00);
    rd_chk("R1 en", 1, 8'h00);
    rd_chk("R1 mode", 2, 8'h03);
    check("R1 start", 32'(dma_start), 0);
    check("R1 irq", 32'(cpu_irq), 0);
  endtask

  task automatic t_set_only;
    wr(0, 8'h05); rd_chk("R2 req set", 0, 8'h05);
    wr(0, 8'h02); rd_chk("R2 req zeros kept", 0, 8'h07);
    wr(1, 8'hA0); wr(1, 8'h00); rd_chk("R2 en zeros kept", 1, 8'hA0);
  endtask

  task automatic t_modes;
    wr(2, 8'h02); rd_chk("R4 mode rw", 2, 8'h02);
    wr(0, 8'h01); rd_chk("R3 req loaded", 0, 8'h01);
    wr(1, 8'h00); rd_chk("R4 en still set-only", 1, 8'hA0);
    wr(2, 8'h00); rd_chk("R4 mode both rw", 2, 8'h00);
    wr(1, 8'h05); rd_chk("R3 en loaded", 1, 8'h05);
    wr(0, 8'h0F);
  endtask

  task automatic t_route_cpu;
    pulse_evt(8'h02);  // src1: req=1 en=0
    check("R5 normal path flag", 32'(irq_src), 32'h02);
    check("R5 no start", 32'(dma_start), 0);
    cpu_ack = 8'h02; tick; cpu_ack = 0;
    check("R12 ack clears", 32'(cpu_irq), 0);
  endtask

  task automatic t_bypass;
    cpu_gie = 0; irq_mask = 0; src_lvl = 0; cpu_lvl = 7;
    pulse_evt(8'h04);  // src2: req=1 en=1
    check("R6 start despite masks", 32'(dma_start), 1);
    check("R7 chan src2", 32'(dma_chan), 32'(exp_chan(2)));
    check("R5 no cpu flag", 32'(cpu_irq), 0);
    dma_ack = 1; tick; dma_ack = 0;
    check("R9 start drops", 32'(dma_start), 0);
    rd_chk("R8 req cleared", 0, 8'h0B);
    dma_done = 1; tick; dma_done = 0;
    check("R12 gated off", 32'(cpu_irq), 0);
    cpu_gie = 1; irq_mask = 8'hFF; src_lvl = {8{3'd5}}; cpu_lvl = 0; #1;
    check("R10 plain done flag", 32'(irq_src), 32'h04);
    cpu_ack = 8'hFF; tick; cpu_ack = 0;
  endtask

  task automatic t_arbitrate;
    wr(0, 8'hFF); wr(1, 8'hFF);
    pulse_evt(8'h28);  // src3 and src5
    check("R9 lowest first", 32'(dma_chan), 32'(exp_chan(3)));
    dma_ack = 1; tick; dma_ack = 0;
    tick; tick; tick;
    check("R9 waits for done", 32'(dma_start), 0);
    dma_done = 1; dma_linked = 1; tick; dma_done = 0; dma_linked = 0;
    check("R9 second start", 32'(dma_start), 1);
    check("R7 chan src5", 32'(dma_chan), 32'(exp_chan(5)));
    check("R11 linked no flag", 32'(irq_src), 0);
    dma_ack = 1; tick; dma_ack = 0;
    dma_done = 1; tick; dma_done = 0;
    check("R10 src5 flag", 32'(irq_src), 32'h20);
    cpu_ack = 8'hFF; tick; cpu_ack = 0;
  endtask

  task automatic t_clear_race;
    pulse_evt(8'h40);
    check("R7 chan src6", 32'(dma_chan), 32'(exp_chan(6)));
    bus_wr = 1; bus_addr = 0; bus_wdata = 8'hFF; dma_ack = 1; tick;
    bus_wr = 0; dma_ack = 0;
    rd_chk("R8 hw clear wins", 0, 8'hBF);
    dma_done = 1; dma_linked = 1; tick; dma_done = 0; dma_linked = 0;
  endtask

  task automatic t_level_gate;
    wr(0, 8'h00);
    src_lvl = {3'd3, {7{3'd5}}}; cpu_lvl = 3;
    pulse_evt(8'h80);
    check("R12 equal level blocked", 32'(cpu_irq), 0);
    cpu_lvl = 2; #1;
    check("R12 higher level passes", 32'(irq_src), 32'h80);
    irq_mask = 8'h7F; #1;
    check("R12 mask blocks", 32'(cpu_irq), 0);
    cpu_ack = 8'h80; tick; cpu_ack = 0;
  endtask

  initial begin
    repeat (2) tick;
    rst_n = 1; tick;
    t_reset;
    t_set_only;
    t_modes;
    t_route_cpu;
    t_bypass;
    t_arbitrate;
    t_clear_race;
    t_level_gate;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule